// File: doc/BRIEF.md
# UART Line Polarity and Status Register Slice

This block holds the software-visible option and status state of one UART channel. Two registers sit behind a byte-wide register port. The option register carries two line-polarity controls. One inverts the serial output on its way from the UART core to the pin. The other inverts the pin level before that level enters the core's receiver. The status register shows whether a transmission is in progress and keeps three sticky receive error flags: parity, framing and overrun.

The channel control logic supplies three levels: a power level and one enable per direction. These levels decide when the polarity controls may change and when flags are forced to zero. The external UART core supplies single-cycle error pulses, a busy level and the serial data. The inverted receive line passes through a reset-to-idle synchronizer before it goes back to the core.

Top module: `uart_optstat_regs`

## Requirements
- R1: After reset, the option register reads 0x14, the status register reads 0x00 and the receive output is 1.
- R2: Option bits 7:2 always read 000101, whatever has been written to them.
- R3: `tx_pin_o` equals `tx_data_i` XOR option bit 1, in the same cycle.
- R4: `rx_data_o` equals `rx_pin_i` XOR option bit 0, delayed by two clock edges.
- R5: A write to offset 0 loads option bit 1 only while `pwr_i`=0 or `txe_i`=0. At other times that bit keeps its value.
- R6: A write to offset 0 loads option bit 0 only while `pwr_i`=0 or `rxe_i`=0. At other times that bit keeps its value.
- R7: Status bits 2, 1 and 0 hold the parity, framing and overrun errors. A one-cycle pulse on the matching event input, while `pwr_i`=1 and `rxe_i`=1, sets the bit from the next cycle on.
- R8: Writing 0 to an error bit at offset 1 clears it. Writing 1 leaves it unchanged.
- R9: When an error event and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Every error bit reads 0 in the cycle after a cycle with `pwr_i`=0 or `rxe_i`=0.
- R11: Status bit 7 reads the previous cycle's `tx_busy_i` while `pwr_i`=1 and `txe_i`=1, and 0 otherwise. Writes do not affect it.
- R12: Status bits 6:3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register offset: 0 option, 1 status |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| pwr_i | input | 1 | Channel power level |
| txe_i | input | 1 | Transmit enable level |
| rxe_i | input | 1 | Receive enable level |
| tx_busy_i | input | 1 | Transmit-in-progress level from the UART core |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| ovr_err_i | input | 1 | Overrun error pulse |
| tx_data_i | input | 1 | Serial data from the transmitter |
| tx_pin_o | output | 1 | Serial data to the pin |
| rx_pin_i | input | 1 | Serial data from the pin |
| rx_data_o | output | 1 | Synchronized, polarity-corrected data to the receiver |

## Verification
A wrongly held polarity bit shows up at the ports in two ways. It flips `tx_pin_o` at once, in the same cycle. It corrupts `rx_data_o` two edges later. An option read at offset 0 shows it in the cycle after the write that should or should not have taken. Error flag and busy state is visible on a status read one cycle after the event, write or enable drop that changed it. A lost set-versus-clear priority or a missed forced clear therefore appears on the next read. The bench reads both offsets every cycle under random power, enable, write and event traffic, so any divergence is caught within one cycle of its cause.

// File: rtl/uart_optstat_pkg.sv
package uart_optstat_pkg;
  localparam int unsigned ADDR_W = 1;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_ERR  = 3;

  localparam logic [ADDR_W-1:0] ADDR_OPT  = 1'b0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 1'b1;

  localparam logic [DATA_W-1:0] OPT_RESET = 8'h14;
  localparam int unsigned OPT_TXINV = 1;
  localparam int unsigned OPT_RXINV = 0;

  localparam int unsigned STAT_BUSY = 7;
  // error vector order: {parity, framing, overrun}
  localparam int unsigned ERR_PAR = 2;
  localparam int unsigned ERR_FRM = 1;
  localparam int unsigned ERR_OVR = 0;
endpackage

// File: rtl/uart_line_inv.sv
module uart_line_inv #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic        IDLE_LVL    = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_inv_i,
  input  logic rx_inv_i,
  input  logic tx_data_i,
  output logic tx_pin_o,
  input  logic rx_pin_i,
  output logic rx_data_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  assign tx_pin_o = tx_data_i ^ tx_inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {SYNC_STAGES{IDLE_LVL}};
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin_i ^ rx_inv_i};
  end

  assign rx_data_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/uart_err_flags.sv
module uart_err_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         keep_i,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (!keep_i)  q_o[g] <= 1'b0;
      else if (ev_i[g])  q_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_optstat_regs.sv
module uart_optstat_regs
  import uart_optstat_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pwr_i,
  input  logic              txe_i,
  input  logic              rxe_i,
  input  logic              tx_busy_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              ovr_err_i,
  input  logic              tx_data_i,
  output logic              tx_pin_o,
  input  logic              rx_pin_i,
  output logic              rx_data_o
);
  logic             tx_inv_q, rx_inv_q, tsf_q;
  logic [N_ERR-1:0] err_q, err_ev, err_clr;
  logic             opt_wr, stat_wr, rx_live, tx_live;
  logic             unused_wdata;

  assign opt_wr  = we_i && (addr_i == ADDR_OPT);
  assign stat_wr = we_i && (addr_i == ADDR_STAT);
  assign rx_live = pwr_i && rxe_i;
  assign tx_live = pwr_i && txe_i;
  assign unused_wdata = ^wdata_i[DATA_W-1:N_ERR];

  // polarity bits lock while their direction is live
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_inv_q <= OPT_RESET[OPT_TXINV];
      rx_inv_q <= OPT_RESET[OPT_RXINV];
    end else if (opt_wr) begin
      if (!tx_live) tx_inv_q <= wdata_i[OPT_TXINV];
      if (!rx_live) rx_inv_q <= wdata_i[OPT_RXINV];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tsf_q <= 1'b0;
    else         tsf_q <= tx_live && tx_busy_i;
  end

  always_comb begin
    err_ev           = '0;
    err_ev[ERR_PAR]  = par_err_i;
    err_ev[ERR_FRM]  = frm_err_i;
    err_ev[ERR_OVR]  = ovr_err_i;
    err_clr          = stat_wr ? ~wdata_i[N_ERR-1:0] : '0;
  end

  uart_err_flags #(.N(N_ERR)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .keep_i (rx_live),
    .ev_i   (err_ev),
    .clr_i  (err_clr),
    .q_o    (err_q)
  );

  uart_line_inv #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_inv_i  (tx_inv_q),
    .rx_inv_i  (rx_inv_q),
    .tx_data_i (tx_data_i),
    .tx_pin_o  (tx_pin_o),
    .rx_pin_i  (rx_pin_i),
    .rx_data_o (rx_data_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_OPT) begin
      rdata_o            = OPT_RESET;
      rdata_o[OPT_TXINV] = tx_inv_q;
      rdata_o[OPT_RXINV] = rx_inv_q;
    end else begin
      rdata_o[STAT_BUSY]   = tsf_q;
      rdata_o[N_ERR-1:0]   = err_q;
    end
  end
endmodule

// File: rtl/uart_optstat_chk.sv
module uart_optstat_chk
  import uart_optstat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic              pwr_i,
  input logic              txe_i,
  input logic              rxe_i,
  input logic              par_err_i,
  input logic              tx_inv_q,
  input logic              rx_inv_q,
  input logic              tsf_q,
  input logic [N_ERR-1:0]  err_q
);
  assert_opt_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_OPT) |-> (rdata_o[7:2] == 6'b000101));

  assert_stat_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> (rdata_o[6:3] == 4'b0000));

  assert_txinv_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && txe_i) |=> $stable(tx_inv_q));

  assert_rxinv_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && rxe_i) |=> $stable(rx_inv_q));

  assert_err_forced_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_i || !rxe_i) |=> (err_q == '0));

  assert_busy_forced_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_i || !txe_i) |=> !tsf_q);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && rxe_i && par_err_i) |=> err_q[ERR_PAR]);

  assert_one_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i && rxe_i && we_i && (addr_i == ADDR_STAT) && wdata_i[ERR_OVR] && err_q[ERR_OVR])
    |=> err_q[ERR_OVR]);
endmodule

bind uart_optstat_regs uart_optstat_chk u_chk (.*);

// File: tb/sim_uart_optstat_regs.sv
module sim_uart_optstat_regs;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [0:0] addr;
  logic       we;
  logic [7:0] wdata, rdata;
  logic pwr, txe, rxe, busy, par, frm, ovr, txd, txp, rxp, rxd;

  int checks = 0, fails = 0;
  bit done = 0;

  // model
  logic m_txinv, m_rxinv, m_tsf, s1, s2;
  logic [2:0] m_err;

  uart_optstat_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pwr_i(pwr), .txe_i(txe), .rxe_i(rxe), .tx_busy_i(busy),
    .par_err_i(par), .frm_err_i(frm), .ovr_err_i(ovr), .tx_data_i(txd),
    .tx_pin_o(txp), .rx_pin_i(rxp), .rx_data_o(rxd)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_opt();
    return 8'h14 | {6'b0, m_txinv, m_rxinv};
  endfunction

  function automatic logic [7:0] exp_stat();
    return {m_tsf, 4'b0, m_err};
  endfunction

  task automatic model_reset();
    m_txinv = 0; m_rxinv = 0; m_tsf = 0; m_err = '0; s1 = 1; s2 = 1;
  endtask

  task automatic model_edge();
    logic ns1;
    logic [2:0] ev;
    ns1 = rxp ^ m_rxinv;
    s2 = s1; s1 = ns1;
    if (we && addr == 1'b0) begin
      if (!pwr || !txe) m_txinv = wdata[1];
      if (!pwr || !rxe) m_rxinv = wdata[0];
    end
    m_tsf = pwr && txe && busy;
    ev = {par, frm, ovr};
    for (int i = 0; i < 3; i++) begin
      if (!(pwr && rxe))                        m_err[i] = 0;
      else if (ev[i])                           m_err[i] = 1;
      else if (we && addr == 1'b1 && !wdata[i]) m_err[i] = 0;
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_all();
    logic [0:0] a;
    a = addr;
    addr = 1'b0; #1;
    chk("R2 opt fixed", {rdata[7:2], 2'b0}, {exp_opt() & 8'hFC});
    chk("R5 tx inv",    {7'b0, rdata[1]}, {7'b0, m_txinv});
    chk("R6 rx inv",    {7'b0, rdata[0]}, {7'b0, m_rxinv});
    addr = 1'b1; #1;
    chk("R11 busy",     {7'b0, rdata[7]}, {7'b0, m_tsf});
    chk("R12 stat zero",{4'b0, rdata[6:3]}, 8'h00);
    chk("R7 err flags", {5'b0, rdata[2:0]}, {5'b0, m_err});
    chk("R3 tx pin",    {7'b0, txp}, {7'b0, txd ^ m_txinv});
    chk("R4 rx data",   {7'b0, rxd}, {7'b0, s2});
    addr = a; #1;
  endtask

  task automatic idle_in();
    we = 0; par = 0; frm = 0; ovr = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 0; addr = 0; we = 0; wdata = 0; pwr = 0; txe = 0; rxe = 0;
    busy = 0; par = 0; frm = 0; ovr = 0; txd = 1; rxp = 1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    addr = 0; #1; chk("R1 opt reset", rdata, 8'h14);
    addr = 1; #1; chk("R1 stat reset", rdata, 8'h00);
    chk("R1 rx idle", {7'b0, rxd}, 8'h01);

    // R5/R6: writes while live are ignored
    pwr = 1; txe = 1; rxe = 1; cycle();
    addr = 0; we = 1; wdata = 8'hFF; cycle(); idle_in();
    addr = 0; #1; chk("R5 locked write", {7'b0, rdata[1]}, 8'h00);
    chk("R6 locked write", {7'b0, rdata[0]}, 8'h00);
    chk("R2 after ff write", rdata, 8'h14);
    // txe off: tx inv loads, rx still locked
    txe = 0; we = 1; wdata = 8'h03; cycle(); idle_in();
    #1; chk("R5 open write", rdata, 8'h16);
    chk("R3 tx inverted", {7'b0, txp}, {7'b0, ~txd});
    // rxe off: rx inv loads
    rxe = 0; we = 1; wdata = 8'h01; cycle(); idle_in();
    #1; chk("R6 open write", rdata, 8'h15);
    rxp = 0; cycle(); cycle();
    chk("R4 rx inverted", {7'b0, rxd}, 8'h01);
    check_all();

    // R7/R8/R9/R10
    txe = 1; rxe = 1; cycle();
    par = 1; cycle(); idle_in();
    addr = 1; #1; chk("R7 parity set", rdata, 8'h04);
    we = 1; wdata = 8'h07; cycle(); idle_in();
    #1; chk("R8 write one keeps", rdata, 8'h04);
    we = 1; wdata = 8'h03; cycle(); idle_in();
    #1; chk("R8 write zero clears", rdata, 8'h00);
    frm = 1; we = 1; wdata = 8'h00; cycle(); idle_in();
    #1; chk("R9 set wins", rdata, 8'h02);
    ovr = 1; cycle(); idle_in();
    #1; chk("R7 overrun set", rdata, 8'h03);
    rxe = 0; cycle();
    #1; chk("R10 rxe drop clears", rdata, 8'h00);
    rxe = 1; ovr = 1; cycle(); idle_in();
    pwr = 0; cycle();
    #1; chk("R10 pwr drop clears", rdata, 8'h00);
    // R11
    pwr = 1; txe = 1; busy = 1; cycle();
    #1; chk("R11 busy mirrors", rdata, 8'h80);
    we = 1; wdata = 8'h00; cycle(); idle_in();
    #1; chk("R11 busy not writable", rdata, 8'h80);
    txe = 0; cycle();
    #1; chk("R11 busy forced off", rdata, 8'h00);
    check_all();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      pwr   = ($urandom % 10) < 8;
      txe   = ($urandom % 4) != 0;
      rxe   = ($urandom % 4) != 0;
      busy  = $urandom % 2;
      par   = ($urandom % 10) == 0;
      frm   = ($urandom % 10) == 0;
      ovr   = ($urandom % 10) == 0;
      we    = ($urandom % 10) < 3;
      addr  = $urandom % 2;
      wdata = 8'($urandom);
      txd   = $urandom % 2;
      rxp   = $urandom % 2;
      cycle();
      check_all();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule